// File: doc/BRIEF.md
# I2C Bus Symbol Transmitter

This block places one two-wire bus symbol on the data line per request: a START, a STOP, a data 0 or a data 1. It does not generate the serial clock. It watches the filtered clock level and times every data-line change against the most recent clock edge, so the same logic meets setup and hold margins whether this device drives the clock or another device does. A byte engine above it raises one of four request lines and waits for the acknowledge. Below it, a pad stage turns the drive value and enable into an open-drain output. The pad pulls low only when the enable is set and the drive value is 0. A drive value of 1 releases the line.

Timing comes from a phase counter. It restarts on every clock edge and counts up while the level holds, stopping at the half-period divider. A data change is allowed only in a window between one quarter and one half of the divider. There are two exceptions:
- **Stretched bus.** If a full divider period passes with the level unchanged, the bus is treated as stretched and changes are allowed at any time.
- **One change per phase.** After a change, a block flag forbids a second change until the clock level flips.

The state machine has six states:
- **IDLE** waits for a request and handles the acknowledge and the enable release.
- **START_SET** drives the line low in a high phase.
- **DATA_SET** drives the bit in a low phase.
- **SYM_DONE** waits for a later allowed slot, then acknowledges.
- **STOP_SET** drives the line low in a low phase.
- **STOP_REL** releases the line in a high phase and acknowledges.

The transitions are:
- IDLE to START_SET, STOP_SET or DATA_SET when the acknowledge is low and a request is present (priority START, then STOP, then data).
- START_SET to SYM_DONE on a high-phase slot.
- DATA_SET to SYM_DONE on a low-phase slot.
- SYM_DONE to IDLE on any slot.
- STOP_SET to STOP_REL on a low-phase slot.
- STOP_REL to IDLE on a high-phase slot.

Top module: `i2c_sym_tx`

## Requirements
- R1: Four-phase handshake. A request is accepted only while `ack` is low. `ack` rises when the symbol completes, stays high while any request line is high, and falls the cycle after all four request lines are low.
- R2: The phase counter restarts at every change of the registered clock level and counts up while the level holds, saturating at `half_div`.
- R3: In free-running operation, a data-line change is made only when the phase count is greater than `half_div>>2` and less than `half_div>>1`, and never on a clock-edge cycle.
- R4: When the clock level stays unchanged for a full `half_div` count with no block pending, the line is considered clear and changes are allowed at any count. The flag clears at the next clock edge. A pending block costs one extra full count before it is dropped.
- R5: At most one data-line change is made per clock phase. A change in a low phase is blocked until the next rising edge, and a change in a high phase is blocked until the next falling edge.
- R6: START pulls the data line low during a clock high phase, with `scl_hold_hi` asserted in that same cycle.
- R7: A data bit sets `sda_val` to the requested bit (data 1 means release, data 0 means pull low) with `sda_oe` set, during a clock low phase. `ack` follows in a later phase.
- R8: STOP pulls the data line low in a low phase with `scl_hold_hi` set. It then releases the line in the following high phase and raises `ack` in that same step, leaving the line released.
- R9: After a completed data or START symbol that left the line pulled low, the enable is kept for 7 idle cycles (a 3-bit holdoff) before it drops. Back-to-back symbols therefore keep driving the line.
- R10: When the driven value is 1, the enable drops one cycle after entering idle, without waiting for the holdoff.
- R11: After reset, `ack` and `sda_oe` are 0, `sda_val` is 1 and `scl_hold_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Filtered serial clock level |
| half_div | input | DIV_W | Clock half-period divider |
| req_start | input | 1 | Request a START symbol |
| req_stop | input | 1 | Request a STOP symbol |
| req_d0 | input | 1 | Request a data 0 bit |
| req_d1 | input | 1 | Request a data 1 bit |
| sda_val | output | 1 | Data drive value (1 = release) |
| sda_oe | output | 1 | Data drive enable |
| scl_hold_hi | output | 1 | Ask the clock generator to hold the high phase |
| ack | output | 1 | Symbol completion acknowledge |

## Verification
The bench keeps the default parameters (16-bit divider, 3-bit holdoff loaded with 7) and applies a divider of 11 while its own clock model toggles every 10 cycles. The phase count therefore never reaches the divider during free running. This leaves a two-count window in every phase, so a change that lands early, late or twice in one phase shows up directly against the bench's own edge count. Freezing the clock model low for longer than the divider brings the stretched-bus path within reach, including the extra count caused by a pending block. The idle holdoff release and the immediate release after a driven 1 are also observable within a few dozen cycles.

// File: rtl/i2c_sym_pkg.sv
package i2c_sym_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START_SET,
        TX_DATA_SET,
        TX_SYM_DONE,
        TX_STOP_SET,
        TX_STOP_REL
    } tx_state_t;

endpackage

// File: rtl/sym_phase_timer.sv
module sym_phase_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic [DIV_W-1:0] half_div,
    input  logic             set_lo_blk,
    input  logic             set_hi_blk,
    output logic             scl_lvl,
    output logic             win,
    output logic             ok_low,
    output logic             ok_high
);
    localparam int QSH = 2;
    localparam int HSH = 1;

    logic [DIV_W-1:0] cnt;
    logic             clr_f;
    logic             lo_blk;
    logic             hi_blk;
    logic             blk_seen;
    logic             scl_q;
    logic             edg;
    logic [DIV_W-1:0] q_lim;
    logic [DIV_W-1:0] h_lim;

    assign edg     = scl_in ^ scl_q;
    assign q_lim   = half_div >> QSH;
    assign h_lim   = half_div >> HSH;
    assign scl_lvl = scl_q;
    assign win     = ((cnt > q_lim) && (cnt < h_lim)) || clr_f;
    assign ok_low  = win && !edg && !scl_q && !lo_blk;
    assign ok_high = win && !edg &&  scl_q && !hi_blk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            cnt      <= '0;
            clr_f    <= 1'b0;
            lo_blk   <= 1'b0;
            hi_blk   <= 1'b0;
            blk_seen <= 1'b0;
        end else begin
            scl_q <= scl_in;
            if (edg) begin
                cnt      <= '0;
                clr_f    <= 1'b0;
                blk_seen <= 1'b0;
                if (!scl_in) hi_blk <= 1'b0;
                else         lo_blk <= 1'b0;
            end else if (cnt < half_div) begin
                cnt <= cnt + 1'b1;
            end else if ((lo_blk || hi_blk) && !blk_seen) begin
                cnt      <= '0;
                blk_seen <= 1'b1;
            end else begin
                clr_f    <= 1'b1;
                blk_seen <= 1'b0;
                lo_blk   <= 1'b0;
                hi_blk   <= 1'b0;
            end
            if (set_lo_blk) lo_blk <= 1'b1;
            if (set_hi_blk) hi_blk <= 1'b1;
        end
    end

    // R2: every level change restarts the phase count
    a_r2_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in != scl_q) |=> (cnt == '0));

    // R4: the line-clear flag never survives a clock edge
    a_r4_edge_drops_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in != scl_q) |=> !clr_f);

    // R5: a block requested in a phase is in force next cycle
    a_r5_block_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (set_lo_blk && !edg) |=> !ok_low);

endmodule

// File: rtl/sym_holdoff.sv
module sym_holdoff #(
    parameter int HOLD_W    = 3,
    parameter int HOLD_LOAD = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic busy
);
    localparam logic [HOLD_W-1:0] LOAD_V = HOLD_W'(HOLD_LOAD);

    logic [HOLD_W-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= LOAD_V;
        else if (step && cnt != '0) cnt <= cnt - 1'b1;
    end

endmodule

// File: rtl/i2c_sym_tx.sv
module i2c_sym_tx
    import i2c_sym_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int HOLD_W    = 3,
    parameter int HOLD_LOAD = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic [DIV_W-1:0] half_div,
    input  logic             req_start,
    input  logic             req_stop,
    input  logic             req_d0,
    input  logic             req_d1,
    output logic             sda_val,
    output logic             sda_oe,
    output logic             scl_hold_hi,
    output logic             ack
);
    tx_state_t st, st_n;
    logic      req_any;
    logic      ok_low, ok_high, ok_any, win, scl_lvl;
    logic      set_lo, set_hi;
    logic      hold_busy, hold_load, hold_step;
    logic      pad_low;

    assign req_any   = req_start | req_stop | req_d0 | req_d1;
    assign ok_any    = ok_low | ok_high;
    assign set_lo    = ((st == TX_DATA_SET) || (st == TX_STOP_SET)) && ok_low;
    assign set_hi    = ((st == TX_START_SET) || (st == TX_STOP_REL)) && ok_high;
    assign hold_load = (st == TX_SYM_DONE) && ok_any;
    assign hold_step = (st == TX_IDLE);
    assign pad_low   = sda_oe && !sda_val;

    sym_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .half_div   (half_div),
        .set_lo_blk (set_lo),
        .set_hi_blk (set_hi),
        .scl_lvl    (scl_lvl),
        .win        (win),
        .ok_low     (ok_low),
        .ok_high    (ok_high)
    );

    sym_holdoff #(.HOLD_W(HOLD_W), .HOLD_LOAD(HOLD_LOAD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hold_load),
        .step  (hold_step),
        .busy  (hold_busy)
    );

    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE: begin
                if (!ack && req_any) begin
                    if (req_start)     st_n = TX_START_SET;
                    else if (req_stop) st_n = TX_STOP_SET;
                    else               st_n = TX_DATA_SET;
                end
            end
            TX_START_SET: if (ok_high) st_n = TX_SYM_DONE;
            TX_DATA_SET:  if (ok_low)  st_n = TX_SYM_DONE;
            TX_SYM_DONE:  if (ok_any)  st_n = TX_IDLE;
            TX_STOP_SET:  if (ok_low)  st_n = TX_STOP_REL;
            TX_STOP_REL:  if (ok_high) st_n = TX_IDLE;
            default:                   st_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_val     <= 1'b1;
            sda_oe      <= 1'b0;
            scl_hold_hi <= 1'b0;
            ack         <= 1'b0;
        end else begin
            unique case (st)
                TX_IDLE: begin
                    scl_hold_hi <= 1'b0;
                    if (!req_any) ack <= 1'b0;
                    if (sda_val)         sda_oe <= 1'b0;
                    else if (!hold_busy) sda_oe <= 1'b0;
                end
                TX_START_SET: begin
                    if (ok_high) begin
                        sda_val     <= 1'b0;
                        sda_oe      <= 1'b1;
                        scl_hold_hi <= 1'b1;
                    end
                end
                TX_DATA_SET: begin
                    if (ok_low) begin
                        sda_val <= req_d1;
                        sda_oe  <= 1'b1;
                    end
                end
                TX_SYM_DONE: begin
                    scl_hold_hi <= 1'b0;
                    if (ok_any) ack <= 1'b1;
                end
                TX_STOP_SET: begin
                    if (ok_low) begin
                        sda_val     <= 1'b0;
                        sda_oe      <= 1'b1;
                        scl_hold_hi <= 1'b1;
                    end
                end
                TX_STOP_REL: begin
                    if (ok_high) begin
                        sda_val     <= 1'b1;
                        sda_oe      <= 1'b1;
                        ack         <= 1'b1;
                        scl_hold_hi <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: acknowledge holds while any request stays high
    a_r1_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_any) |=> ack);

    // R3: a pad change made by a symbol state falls inside an allowed slot
    a_r3_change_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st) != TX_IDLE) && (pad_low != $past(pad_low))) |-> $past(win));

    // R9: a low drive is only released once the holdoff has run out
    a_r9_holdoff_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !$past(sda_val)) |-> !$past(hold_busy));

    // R10: a released line loses its enable right after idle is entered
    a_r10_release_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE && sda_val && sda_oe) |=> !sda_oe);

endmodule

// File: tb/i2c_sym_tx_bench.sv
`timescale 1ns/1ps
module i2c_sym_tx_bench;

    localparam int HALF    = 10;
    localparam int DIVV    = 11;
    localparam int NSEQ    = 12;
    localparam int SEQ [NSEQ] = '{0, 3, 2, 2, 3, 3, 2, 1, 0, 2, 3, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic [15:0] half_div = 16'(DIVV);
    logic        req_start = 1'b0, req_stop = 1'b0, req_d0 = 1'b0, req_d1 = 1'b0;
    logic        sda_val, sda_oe, scl_hold_hi, ack;

    int n_chk = 0;
    int n_fail = 0;

    // monitor state (written only by the negedge block)
    logic gen_on = 1'b0;
    logic mon_on = 1'b0;
    int   k = 0;
    logic pad_prev = 1'b0;
    logic chg_in_phase = 1'b0;
    int   err_win = 0, err_multi = 0, err_phase = 0;
    logic hold_at_fall = 1'b0;
    logic exp_fall_lvl = 1'b1, exp_rise_lvl = 1'b1;

    always #2.5 clk = ~clk;

    i2c_sym_tx u_i2c_sym_tx (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .half_div(half_div),
        .req_start(req_start), .req_stop(req_stop), .req_d0(req_d0), .req_d1(req_d1),
        .sda_val(sda_val), .sda_oe(sda_oe), .scl_hold_hi(scl_hold_hi), .ack(ack)
    );

    always @(negedge clk) begin
        logic pad_now;
        pad_now = sda_oe && !sda_val;
        if (mon_on && pad_now != pad_prev) begin
            if (k < 3 || k > 7) err_win = err_win + 1;
            if (chg_in_phase)   err_multi = err_multi + 1;
            if (scl != (pad_now ? exp_fall_lvl : exp_rise_lvl)) err_phase = err_phase + 1;
            if (pad_now) hold_at_fall = scl_hold_hi;
            chg_in_phase = 1'b1;
        end
        pad_prev = pad_now;
        if (gen_on) begin
            if (k == HALF - 1) begin
                scl <= ~scl;
                k = 0;
                chg_in_phase = 1'b0;
            end else begin
                k = k + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic set_req(input int code, input logic v);
        case (code)
            0: req_start = v;
            1: req_stop  = v;
            2: req_d0    = v;
            default: req_d1 = v;
        endcase
    endtask

    task automatic wait_ack(input logic lvl, output int cyc);
        cyc = 0;
        while (ack !== lvl && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // run one symbol in free-running clock mode
    task automatic run_sym(input int code, inout logic exp_pad);
        int w0, m0, p0, cyc;
        string tag;
        w0 = err_win; m0 = err_multi; p0 = err_phase;
        case (code)
            0: begin exp_fall_lvl = 1'b1; exp_rise_lvl = 1'b1; exp_pad = 1'b1; tag = "R6"; end
            1: begin exp_fall_lvl = 1'b0; exp_rise_lvl = 1'b1; exp_pad = 1'b0; tag = "R8"; end
            2: begin exp_fall_lvl = 1'b0; exp_rise_lvl = 1'b0; exp_pad = 1'b1; tag = "R7"; end
            default: begin exp_fall_lvl = 1'b0; exp_rise_lvl = 1'b0; exp_pad = 1'b0; tag = "R7"; end
        endcase
        hold_at_fall = 1'b0;
        set_req(code, 1'b1);
        wait_ack(1'b1, cyc);
        check(ack === 1'b1, "R1 ack rises", int'(ack), 1);
        check(err_win == w0, "R3 change slot", err_win - w0, 0);
        check(err_multi == m0, "R5 one change per phase", err_multi - m0, 0);
        check(err_phase == p0, {tag, " change phase"}, err_phase - p0, 0);
        check((sda_oe && !sda_val) == exp_pad, {tag, " pad level"}, int'(sda_oe && !sda_val), int'(exp_pad));
        if (code == 0) check(hold_at_fall == 1'b1, "R6 hold high at fall", int'(hold_at_fall), 1);
        set_req(code, 1'b0);
        if (code == 3 || code == 1) begin
            @(negedge clk);
            check(sda_oe == 1'b0, "R10 enable drop", int'(sda_oe), 0);
        end
        wait_ack(1'b0, cyc);
        check(ack === 1'b0 && cyc <= 2, "R1 ack falls", cyc, 1);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic exp_pad;
        int cyc;
        exp_pad = 1'b0;
        repeat (4) @(negedge clk);
        // R11 reset state
        check(ack == 1'b0 && sda_oe == 1'b0, "R11 ack/oe reset", int'({ack, sda_oe}), 0);
        check(sda_val == 1'b1 && scl_hold_hi == 1'b0, "R11 val/hold reset",
              int'({sda_val, scl_hold_hi}), 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        gen_on = 1'b1;
        mon_on = 1'b1;
        repeat (25) @(negedge clk);

        for (int i = 0; i < NSEQ; i++) begin
            run_sym(SEQ[i], exp_pad);
        end

        // R4: freeze the clock low right after a falling edge
        while (!(scl == 1'b0 && k == 0)) @(negedge clk);
        gen_on = 1'b0;
        mon_on = 1'b0;
        repeat (30) @(negedge clk);
        req_d0 = 1'b1;
        cyc = 0;
        while (!(sda_oe && !sda_val) && cyc < 10) begin @(negedge clk); cyc++; end
        check(cyc <= 4, "R4 change while stretched", cyc, 2);
        wait_ack(1'b1, cyc);
        check(ack === 1'b1 && cyc <= 40, "R4 ack after extra count", cyc, 26);
        req_d0 = 1'b0;
        // R9 holdoff keeps the line low for 7 idle cycles
        repeat (4) @(negedge clk);
        check(sda_oe && !sda_val, "R9 still driven", int'(sda_oe), 1);
        repeat (8) @(negedge clk);
        check(sda_oe == 1'b0, "R9 released after holdoff", int'(sda_oe), 0);

        // R1: acknowledge held while request held
        req_d1 = 1'b1;
        wait_ack(1'b1, cyc);
        check(ack === 1'b1, "R1 ack for held request", int'(ack), 1);
        repeat (5) @(negedge clk);
        check(ack === 1'b1, "R1 ack stays while held", int'(ack), 1);
        check(sda_oe == 1'b0, "R10 release drops enable", int'(sda_oe), 0);
        req_d1 = 1'b0;
        @(negedge clk);
        check(ack === 1'b0, "R1 ack clears", int'(ack), 0);
        check(scl == 1'b0, "R4 clock stayed frozen", int'(scl), 0);

        finish_run();
    end

endmodule